// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous 32K x 8 static RAM. The host offers single-beat read or write requests through a request/ready handshake. The controller turns each request into a sequence of chip-select, write-enable and output-enable strobes, all registered. Each phase lasts a whole number of clock cycles. Read data returns to the host with a one-cycle valid pulse.

Every phase length is worked out at elaboration time from the clock period and the memory's timing minima, all given in nanoseconds. A nanosecond figure is divided by the clock period and rounded up, and the result is never less than one cycle. The memory data bus is bidirectional. The controller drives it through an output, an output-enable and an input, and it sequences its own driver against the memory's output enable so the two sides never drive the bus at once.

A parameter selects which strobe ends a write. In one variant, write-enable ends the write while chip-select stays low through the recovery phase. In the other, chip-select ends the write while write-enable stays low.

Top module: `sram_ctl`

## Requirements
- R1: After reset, chip-select, write-enable and output-enable are all high (inactive), the data driver is off, ready_o is high and rvalid_o is low.
- R2: A write holds chip-select and write-enable both low for one unbroken window of ceil(max(pulse width, address-to-end, data setup)/clock) cycles. This is 10 cycles with defaults: 40, 40 and 25 ns on a 4 ns clock. The request's data is driven and stable through the whole window.
- R3: The write data stays driven, and the address stays unchanged, for at least one cycle after the write window ends. The address never changes while write-enable is low.
- R4: A read holds chip-select low, output-enable low and write-enable high, with the driver off, for ceil(max(address access, output-enable access)/clock) cycles. This is 14 cycles with defaults. The bus is captured on the edge that ends this window, so rvalid_o is high for exactly one cycle starting RD+1 cycles after acceptance, with rdata_o equal to the last byte written to that address.
- R5: ready_o is low from the accepting edge until the access is complete. For a write this is max(ceil(cycle time/clock), window+1) cycles, which is 14. For a read it is the read window plus max(1, ceil(output-disable/clock), the cycles left of the cycle time), which is 19.
- R6: The driver is never on while chip-select and output-enable are both low. After output-enable rises, at least ceil(output-disable time/clock) cycles pass before the driver turns on.
- R7: The driver is off in the cycle before output-enable falls.
- R8: With WE_CTRL=1 (default), write-enable ends the write: in the cycle after the window, write-enable is high while chip-select is still low.
- R9: Whenever ready_o is high, the memory is deselected. All three strobes are high and the driver is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, accepted when ready_o is high |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Byte address |
| req_wdata_i | input | DW | Write data |
| ready_o | output | 1 | Controller idle and able to accept |
| rdata_o | output | DW | Read data |
| rvalid_o | output | 1 | One-cycle pulse when rdata_o is valid |
| mem_addr_o | output | AW | Memory address |
| mem_cs_n_o | output | 1 | Chip-select, active low |
| mem_we_n_o | output | 1 | Write-enable, active low |
| mem_oe_n_o | output | 1 | Output-enable, active low |
| mem_dq_o | output | DW | Data to memory |
| mem_dq_oe_o | output | 1 | Data driver enable |
| mem_dq_i | input | DW | Data from memory |

## Verification
The bench uses a timed memory model that returns the inverted byte until 55 ns after the read strobes assert. An early capture therefore shows up as wrong data rather than passing by chance. Directed patterns cover several cases: the lowest and highest addresses, all-zero and all-one bytes, a read followed at once by a write (which tests bus turnaround), and a write followed by a read of the same address (which tests store-then-load). Random operations over a small address pool mix reads and writes so that most reads hit data written earlier. Every write window is measured for length and data stability, and every driver turn-on is measured against the last output-enable release.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WR_PULSE,
    PH_WR_REC,
    PH_RD_ACC,
    PH_RD_REC
  } phase_e;

  // ceil(t/clk), never below one cycle
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int WR_CYC = 10,
  parameter int WR_REC = 4,
  parameter int RD_CYC = 14,
  parameter int RD_REC = 5
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   req_write_i,
  output phase_e phase_d_o,
  output logic   accept_o,
  output logic   capture_o,
  output logic   ready_o
);

  localparam int LMAX  = imax(imax(WR_CYC, WR_REC), imax(RD_CYC, RD_REC));
  localparam int CNT_W = $clog2(LMAX + 1);

  phase_e             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               last;

  assign last = (cnt_q == '0);

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    accept_o  = 1'b0;
    capture_o = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_i) begin
          accept_o = 1'b1;
          if (req_write_i) begin
            phase_d = PH_WR_PULSE;
            cnt_d   = CNT_W'(WR_CYC - 1);
          end else begin
            phase_d = PH_RD_ACC;
            cnt_d   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      PH_WR_PULSE: begin
        if (last) begin
          phase_d = PH_WR_REC;
          cnt_d   = CNT_W'(WR_REC - 1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_WR_REC: begin
        if (last) phase_d = PH_IDLE;
        else      cnt_d   = cnt_q - CNT_W'(1);
      end
      PH_RD_ACC: begin
        if (last) begin
          capture_o = 1'b1;
          phase_d   = PH_RD_REC;
          cnt_d     = CNT_W'(RD_REC - 1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_RD_REC: begin
        if (last) phase_d = PH_IDLE;
        else      cnt_d   = cnt_q - CNT_W'(1);
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_d_o = phase_d;
  assign ready_o   = (phase_q == PH_IDLE);

endmodule

// File: rtl/sram_ctl_strobe.sv
module sram_ctl_strobe
  import sram_ctl_pkg::*;
#(
  parameter bit WE_CTRL = 1'b1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_e phase_d_i,
  output logic   cs_n_o,
  output logic   we_n_o,
  output logic   oe_n_o,
  output logic   drv_o
);

  logic cs_low, we_low, oe_low, drv_on;

  // overlap window is PH_WR_PULSE in both variants; variant picks the terminating strobe
  generate
    if (WE_CTRL) begin : g_we_ends
      assign cs_low = (phase_d_i == PH_WR_PULSE) || (phase_d_i == PH_WR_REC) ||
                      (phase_d_i == PH_RD_ACC);
      assign we_low = (phase_d_i == PH_WR_PULSE);
    end else begin : g_cs_ends
      assign cs_low = (phase_d_i == PH_WR_PULSE) || (phase_d_i == PH_RD_ACC);
      assign we_low = (phase_d_i == PH_WR_PULSE) || (phase_d_i == PH_WR_REC);
    end
  endgenerate

  assign oe_low = (phase_d_i == PH_RD_ACC);
  assign drv_on = (phase_d_i == PH_WR_PULSE) || (phase_d_i == PH_WR_REC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_o <= 1'b1;
      we_n_o <= 1'b1;
      oe_n_o <= 1'b1;
      drv_o  <= 1'b0;
    end else begin
      cs_n_o <= ~cs_low;
      we_n_o <= ~we_low;
      oe_n_o <= ~oe_low;
      drv_o  <= drv_on;
    end
  end

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          capture_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [DW-1:0] mem_dq_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);

  // address and data only move on acceptance, when write-enable is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      mem_dq_o   <= '0;
    end else if (accept_i) begin
      mem_addr_o <= req_addr_i;
      mem_dq_o   <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= capture_i;
      if (capture_i) rdata_o <= mem_dq_i;
    end
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW          = 15,
  parameter int DW          = 8,
  parameter int CLK_NS      = 4,
  parameter int T_CYC_NS    = 55,
  parameter int T_WP_NS     = 40,
  parameter int T_AWE_NS    = 40,
  parameter int T_DS_NS     = 25,
  parameter int T_ACC_NS    = 55,
  parameter int T_OEACC_NS  = 25,
  parameter int T_OHZ_NS    = 20,
  parameter bit WE_CTRL     = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_cs_n_o,
  output logic          mem_we_n_o,
  output logic          mem_oe_n_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int CYC_CYC = ns_to_cyc(T_CYC_NS, CLK_NS);
  localparam int WR_CYC  = ns_to_cyc(imax(imax(T_WP_NS, T_AWE_NS), T_DS_NS), CLK_NS);
  localparam int RD_CYC  = ns_to_cyc(imax(T_ACC_NS, T_OEACC_NS), CLK_NS);
  localparam int OHZ_CYC = ns_to_cyc(T_OHZ_NS, CLK_NS);
  localparam int WR_REC  = imax(1, CYC_CYC - WR_CYC);
  localparam int RD_REC  = imax(imax(1, OHZ_CYC), CYC_CYC - RD_CYC);

  phase_e phase_d;
  logic   accept, capture;

  sram_ctl_seq #(
    .WR_CYC (WR_CYC),
    .WR_REC (WR_REC),
    .RD_CYC (RD_CYC),
    .RD_REC (RD_REC)
  ) seq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .req_write_i (req_write_i),
    .phase_d_o   (phase_d),
    .accept_o    (accept),
    .capture_o   (capture),
    .ready_o     (ready_o)
  );

  sram_ctl_strobe #(
    .WE_CTRL (WE_CTRL)
  ) strobe_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_d_i (phase_d),
    .cs_n_o    (mem_cs_n_o),
    .we_n_o    (mem_we_n_o),
    .oe_n_o    (mem_oe_n_o),
    .drv_o     (mem_dq_oe_o)
  );

  sram_ctl_dpath #(
    .AW (AW),
    .DW (DW)
  ) dpath_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .capture_i   (capture),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .mem_dq_i    (mem_dq_i),
    .mem_addr_o  (mem_addr_o),
    .mem_dq_o    (mem_dq_o),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int AW      = 15,
  parameter int DW      = 8,
  parameter int WR_CYC  = 10,
  parameter int OHZ_CYC = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ready_o,
  input logic          rvalid_o,
  input logic          mem_cs_n_o,
  input logic          mem_we_n_o,
  input logic          mem_oe_n_o,
  input logic          mem_dq_oe_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_dq_o
);

  localparam int OW = $clog2(WR_CYC + 2) + 1;
  localparam int GW = $clog2(OHZ_CYC + 2) + 1;

  logic          ov;
  logic [OW-1:0] ov_cnt;
  logic [GW-1:0] gap;

  assign ov = !mem_cs_n_o && !mem_we_n_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ov_cnt <= '0;
    else if (ov) ov_cnt <= ov_cnt + OW'(1);
    else         ov_cnt <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     gap <= GW'(OHZ_CYC + 1);
    else if (!mem_oe_n_o)            gap <= '0;
    else if (gap < GW'(OHZ_CYC + 1)) gap <= gap + GW'(1);
  end

  AST_WR_WINDOW_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ov && $past(ov)) |-> (ov_cnt == OW'(WR_CYC)));                              // R2
  AST_WR_DATA_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov |-> mem_dq_oe_o);                                                          // R2
  AST_WR_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov && $past(ov)) |-> $stable(mem_dq_o));                                     // R2
  AST_ADDR_HELD_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_n_o && $past(!mem_we_n_o)) |-> $stable(mem_addr_o));                 // R3
  AST_RD_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (!mem_cs_n_o && mem_we_n_o && !mem_dq_oe_o));                 // R4
  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);                                                      // R4
  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_cs_n_o && !mem_oe_n_o));                                // R6
  AST_TURNAROUND_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> (gap >= GW'(OHZ_CYC)));                                // R6
  AST_DRV_OFF_BEFORE_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_oe_n_o) |-> !$past(mem_dq_oe_o));                                   // R7
  AST_IDLE_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_cs_n_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o));        // R9

endmodule

bind sram_ctl sram_ctl_chk #(
  .AW      (AW),
  .DW      (DW),
  .WR_CYC  (WR_CYC),
  .OHZ_CYC (OHZ_CYC)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .mem_cs_n_o  (mem_cs_n_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_dq_oe_o (mem_dq_oe_o),
  .mem_addr_o  (mem_addr_o),
  .mem_dq_o    (mem_dq_o)
);

// File: tb/sram_ctl_tb_top.sv
`timescale 1ns/1ps
module sram_ctl_tb_top;

  localparam int CLK    = 4;
  localparam int T_CYC  = 55;
  localparam int T_WP   = 40;
  localparam int T_AWE  = 40;
  localparam int T_DS   = 25;
  localparam int T_ACC  = 55;
  localparam int T_OEA  = 25;
  localparam int T_OHZ  = 20;

  function automatic int cdiv(input int t);
    int c;
    c = (t + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  function automatic int exp_wr_win();
    return cdiv(mx(mx(T_WP, T_AWE), T_DS));
  endfunction
  function automatic int exp_rd_win();
    return cdiv(mx(T_ACC, T_OEA));
  endfunction
  function automatic int exp_wr_busy();
    return mx(cdiv(T_CYC), exp_wr_win() + 1);
  endfunction
  function automatic int exp_rd_busy();
    return exp_rd_win() + mx(mx(1, cdiv(T_OHZ)), cdiv(T_CYC) - exp_rd_win());
  endfunction

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_wr = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready, rvalid;
  logic [7:0]  rdata;
  logic [14:0] maddr;
  logic        cs_n, we_n, oe_n, dq_oe;
  logic [7:0]  dq_o, dq_i;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit contention_seen = 0;

  always #2 clk = ~clk;

  sram_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_write_i(req_wr),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ready_o(ready),
    .rdata_o(rdata), .rvalid_o(rvalid), .mem_addr_o(maddr),
    .mem_cs_n_o(cs_n), .mem_we_n_o(we_n), .mem_oe_n_o(oe_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] model_mem [int];
  logic [7:0] ref_mem   [int];
  logic       rd_act;
  logic       rd_ok = 1'b0;
  logic [7:0] rd_word = '0;

  function automatic logic [7:0] mrd(input int a);
    return model_mem.exists(a) ? model_mem[a] : 8'h00;
  endfunction
  function automatic logic [7:0] rrd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  assign rd_act = !cs_n && !oe_n && we_n;
  // inverted byte until access time has elapsed
  assign dq_i = rd_act ? (rd_ok ? rd_word : ~rd_word) : (dq_oe ? dq_o : 8'h00);

  always @(posedge rd_act) begin
    rd_ok   = 1'b0;
    rd_word = mrd(int'(maddr));
    #(T_ACC);
    rd_ok = rd_act;
  end
  always @(negedge rd_act) rd_ok = 1'b0;

  // ---------------- bus monitor (mid-cycle) ----------------
  bit         wr_prev = 0, drv_prev = 0, oe_prev_n = 1, drv_bad = 0, we_prev_n = 1;
  int         wlen = 0, dstab = 0, gap = 1000;
  logic [7:0] wd_prev = '0;
  logic [14:0] waddr = '0, addr_prev = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit wr_act;
      wr_act = !cs_n && !we_n;
      if (dq_oe && rd_act) contention_seen = 1;
      if (!we_n && !we_prev_n && maddr != addr_prev)
        chk(0, "R3 addr moved while we_n low", int'(maddr), int'(addr_prev));
      if (wr_act) begin
        if (!wr_prev) begin
          wlen = 0; dstab = 0; drv_bad = 0; waddr = maddr;
        end
        wlen++;
        if (!dq_oe) drv_bad = 1;
        if (dstab > 0 && dq_o == wd_prev) dstab++;
        else dstab = 1;
        wd_prev = dq_o;
      end else if (wr_prev) begin
        chk(wlen == exp_wr_win() && wlen * CLK >= T_WP, "R2 write window cycles", wlen, exp_wr_win());
        chk(dstab * CLK >= T_DS && !drv_bad, "R2 data setup cycles", dstab, exp_wr_win());
        chk(dq_oe && dq_o == wd_prev, "R3 data hold after window", int'(dq_o), int'(wd_prev));
        chk(maddr == waddr, "R3 addr hold after window", int'(maddr), int'(waddr));
        chk(!cs_n && we_n, "R8 write ended by we_n", int'({cs_n, we_n}), 1);
        model_mem[int'(waddr)] = wd_prev;
      end
      if (!oe_n) gap = 0;
      else if (gap < 1000) gap++;
      if (dq_oe && !drv_prev)
        chk(gap * CLK >= T_OHZ + CLK, "R6 turnaround cycles", gap, cdiv(T_OHZ) + 1);
      if (!oe_n && oe_prev_n)
        chk(!drv_prev && !dq_oe, "R7 driver off before oe", int'(drv_prev), 0);
      wr_prev   = wr_act;
      drv_prev  = dq_oe;
      oe_prev_n = oe_n;
      we_prev_n = we_n;
      addr_prev = maddr;
    end
  end

  // ---------------- host tasks ----------------
  task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
    int k, rv_at, rv_cnt;
    logic [7:0] got;
    while (!ready) @(negedge clk);
    chk(cs_n && we_n && oe_n && !dq_oe, "R9 idle deselect", int'({cs_n, we_n, oe_n, dq_oe}), 14);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    k = 1; rv_at = 0; rv_cnt = 0; got = '0;
    forever begin
      if (rvalid) begin rv_at = k; rv_cnt++; got = rdata; end
      if (ready) break;
      k++;
      @(negedge clk);
    end
    if (wr) begin
      ref_mem[int'(a)] = d;
      chk(k - 1 == exp_wr_busy(), "R5 write busy cycles", k - 1, exp_wr_busy());
    end else begin
      chk(k - 1 == exp_rd_busy(), "R5 read busy cycles", k - 1, exp_rd_busy());
      chk(rv_cnt == 1 && rv_at == exp_rd_win() + 1, "R4 rvalid timing", rv_at, exp_rd_win() + 1);
      chk(got == rrd(int'(a)), "R4 read data", int'(got), int'(rrd(int'(a))));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && we_n && oe_n && !dq_oe && !rvalid, "R1 reset strobes", int'({cs_n, we_n, oe_n, dq_oe, rvalid}), 28);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n && we_n && oe_n && !dq_oe && ready && !rvalid, "R1 post-reset idle",
        int'({cs_n, we_n, oe_n, dq_oe, ready, rvalid}), 58);

    // directed corners
    do_op(1, 15'h0000, 8'hA5);
    do_op(1, 15'h7FFF, 8'h5A);
    do_op(0, 15'h0000, 8'h00);
    do_op(1, 15'h0001, 8'hFF);       // read then write: turnaround
    do_op(0, 15'h7FFF, 8'h00);
    do_op(1, 15'h0002, 8'h00);
    do_op(0, 15'h0002, 8'h00);       // store then load
    do_op(0, 15'h0001, 8'h00);
    do_op(0, 15'h1234, 8'h00);       // never written

    // random mix over a small pool
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 60; i++) begin
      bit wr;
      logic [14:0] a;
      wr = ($urandom() % 2) == 0;
      a  = 15'(($urandom() % 12) * 15'h0A3B);
      do_op(wr, a, 8'($urandom()));
    end

    chk(!contention_seen, "R6 no bus contention", int'(contention_seen), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule